// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

An on-chip word memory with one synchronous port, built so that reads and writes can follow each other on every enabled clock without idle slots. Commands (address, direction, select and load/advance) are captured on the rising clock edge. Read data leaves on a registered output bus two enabled edges after its command. Write data, with its per-byte enables, enters on the input bus two enabled edges after its command. A read and a write therefore use the array in the same pipeline slot and never collide.

A load cycle starts a new access at the presented address. An advance cycle continues the access in flight at the next word of its aligned four-word group. Three select inputs count only on load cycles. A clock-enable input freezes the whole pipeline. An asynchronous snooze input parks the block, keeps the array contents and drops any work in flight.

Top module: `zbt_sram`

## Requirements
- R1: A read command on an enabled edge puts the addressed word on `rdata` with `rvalid` high after the second following enabled edge. `rvalid` is low whenever no read result is presented.
- R2: A write command stores `wdata` two enabled edges after the command. Only lanes whose `lane_we_n` bit is 0 at that same edge are stored, and bit i covers `wdata[8i+7:8i]`.
- R3: A read issued one or two cycles after a write to the same word returns the newly written lanes. Lanes that were not enabled keep their earlier contents.
- R4: While `clk_en_n` is 1, clock edges have no effect. `rvalid`, `rdata` and every command in flight hold, and inputs presented during the stall are ignored.
- R5: `rd_nwr` (1 = read, 0 = write) is sampled only when `load_n` is 0. On advance cycles it is ignored and the access keeps its direction.
- R6: When `load_n` is 1 after a selected load, the next access uses the previous address with its two low bits incremented modulo 4, so the upper bits are unchanged (…E, …F, …C).
- R7: The block is selected when `sel0_n`=0, `sel1_n`=0 and `sel2`=1. These are sampled only on load cycles. A deselected load, and any advance that follows it, produce no write and no read result. Deasserting a select during advance cycles does not stop a burst.
- R8: While `snooze` is 1, `rvalid` drops at once and all other inputs are ignored. No write happens and the array contents are kept. After `snooze` returns to 0 the pipeline is empty, and advance cycles produce nothing until a new load.
- R9: After reset, `rvalid` is 0 and `rdata` is 0.
- R10: Read and write commands may be issued on consecutive enabled cycles in any order with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline |
| snooze | input | 1 | Asynchronous retention standby, active high |
| clk_en_n | input | 1 | Active-low clock enable; high stalls everything |
| load_n | input | 1 | 0 = load new address, 1 = advance the current burst |
| rd_nwr | input | 1 | Direction on load cycles: 1 read, 0 write |
| sel0_n | input | 1 | Active-low select, sampled on load |
| sel1_n | input | 1 | Active-low select, sampled on load |
| sel2 | input | 1 | Active-high select, sampled on load |
| addr | input | ADDR_W | Word address |
| lane_we_n | input | LANES | Active-low byte-lane write enables, taken with write data |
| wdata | input | LANES*LANE_W | Write data, taken two enabled edges after the write command |
| rdata | output | LANES*LANE_W | Registered read data |
| rvalid | output | 1 | High while `rdata` carries a read result |

## Verification
A write's data slot and a later read's command can fall on the same edge. This is provoked by a write followed two cycles later by a read of the same word, then by a partial-lane write followed one cycle later by a read, and the returned word is compared lane by lane against a model of the old and new bytes. A stall or a snooze can also land while a read is between its command and its result. The bench holds `clk_en_n` high across that window and raises `snooze` asynchronously while a result is displayed. It judges whether the result arrives late, holds, or is dropped, and whether writes presented during the stall or standby leave the array untouched.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    // Direction of an access as held in the pipeline.
    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } dir_e;

    // All three selects must agree for a load to start an access.
    function automatic logic chip_selected(input logic s0_n, input logic s1_n, input logic s2);
        return (!s0_n) && (!s1_n) && s2;
    endfunction

endpackage

// File: rtl/zbt_addr_gen.sv
module zbt_addr_gen
    import zbt_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              clk_en_n,
    input  logic              load_n,
    input  logic              rd_nwr,
    input  logic              selected,
    input  logic [ADDR_W-1:0] addr,
    output logic              acc_valid,
    output dir_e              acc_dir,
    output logic [ADDR_W-1:0] acc_addr
);

    localparam logic [BURST_W-1:0] STEP = BURST_W'(1);

    typedef struct packed {
        logic              act;
        dir_e              dir;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    cmd_t cmd_d, cmd_q;

    always_comb begin
        cmd_d = cmd_q;
        if (!load_n) begin
            cmd_d.act  = selected;
            cmd_d.dir  = rd_nwr ? DIR_READ : DIR_WRITE;
            cmd_d.addr = addr;
        end else if (cmd_q.act) begin
            cmd_d.addr[BURST_W-1:0] = cmd_q.addr[BURST_W-1:0] + STEP;
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            cmd_q <= '{act: 1'b0, dir: DIR_READ, addr: '0};
        end else if (!clk_en_n) begin
            cmd_q <= cmd_d;
        end
    end

    assign acc_valid = cmd_q.act;
    assign acc_dir   = cmd_q.dir;
    assign acc_addr  = cmd_q.addr;

    AST_BURST_WRAP: assert property (@(posedge clk) disable iff (!clr_n)
        (!clk_en_n && load_n && cmd_q.act) |=>
            (cmd_q.addr[ADDR_W-1:BURST_W] == $past(cmd_q.addr[ADDR_W-1:BURST_W])) &&
            (cmd_q.addr[BURST_W-1:0] == BURST_W'($past(cmd_q.addr[BURST_W-1:0]) + STEP))); // R6

    AST_DIR_FIXED: assert property (@(posedge clk) disable iff (!clr_n)
        (!clk_en_n && load_n) |=> (cmd_q.dir == $past(cmd_q.dir))); // R5

    AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!clr_n)
        (!clk_en_n && !load_n && !selected) |=> !cmd_q.act); // R7

    AST_STALL_CMD: assert property (@(posedge clk) disable iff (!clr_n)
        clk_en_n |=> $stable(cmd_q)); // R4

endmodule

// File: rtl/zbt_lane_mem.sv
module zbt_lane_mem #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [LANES-1:0]        lane_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we && lane_en[g]) begin
                cells[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[addr];
    end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int LANES   = 4,
    parameter int LANE_W  = 8,
    parameter int BURST_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    snooze,
    input  logic                    clk_en_n,
    input  logic                    load_n,
    input  logic                    rd_nwr,
    input  logic                    sel0_n,
    input  logic                    sel1_n,
    input  logic                    sel2,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);

    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        logic              s2_v;
        dir_e              s2_dir;
        logic [ADDR_W-1:0] s2_addr;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic              clr_n;
    logic              s1_v;
    dir_e              s1_dir;
    logic [ADDR_W-1:0] s1_addr;
    logic              mem_we;
    logic [DATA_W-1:0] mem_rd;

    // Snooze clears all pipeline state exactly as reset does.
    assign clr_n = rst_n && !snooze;

    zbt_addr_gen #(
        .ADDR_W  (ADDR_W),
        .BURST_W (BURST_W)
    ) u_addr_gen (
        .clk       (clk),
        .clr_n     (clr_n),
        .clk_en_n  (clk_en_n),
        .load_n    (load_n),
        .rd_nwr    (rd_nwr),
        .selected  (chip_selected(sel0_n, sel1_n, sel2)),
        .addr      (addr),
        .acc_valid (s1_v),
        .acc_dir   (s1_dir),
        .acc_addr  (s1_addr)
    );

    assign mem_we = !clk_en_n && pipe_q.s2_v && (pipe_q.s2_dir == DIR_WRITE);

    zbt_lane_mem #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_mem (
        .clk     (clk),
        .we      (mem_we),
        .lane_en (~lane_we_n),
        .addr    (pipe_q.s2_addr),
        .wdata   (wdata),
        .rdata   (mem_rd)
    );

    always_comb begin
        pipe_d         = pipe_q;
        pipe_d.s2_v    = s1_v;
        pipe_d.s2_dir  = s1_dir;
        pipe_d.s2_addr = s1_addr;
        pipe_d.rvalid  = pipe_q.s2_v && (pipe_q.s2_dir == DIR_READ);
        if (pipe_d.rvalid) begin
            pipe_d.rdata = mem_rd;
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            pipe_q <= '{s2_v: 1'b0, s2_dir: DIR_READ, s2_addr: '0, rvalid: 1'b0, rdata: '0};
        end else if (!clk_en_n) begin
            pipe_q <= pipe_d;
        end
    end

    assign rvalid = pipe_q.rvalid;
    assign rdata  = pipe_q.rdata;

    AST_READ_PRESENTED: assert property (@(posedge clk) disable iff (!clr_n)
        (!clk_en_n && pipe_q.s2_v && pipe_q.s2_dir == DIR_READ) |=> rvalid); // R1

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!clr_n)
        (!clk_en_n && !(pipe_q.s2_v && pipe_q.s2_dir == DIR_READ)) |=> !rvalid); // R1

    AST_STALL_OUTPUT: assert property (@(posedge clk) disable iff (!clr_n)
        clk_en_n |=> ($stable(rvalid) && $stable(rdata))); // R4

    AST_SNOOZE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        snooze |-> (!mem_we && !rvalid)); // R8

endmodule

// File: tb/tb_zbt_sram.sv
module tb_zbt_sram;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        snooze = 1'b0;
    logic        clk_en_n = 1'b0;
    logic        load_n = 1'b1;
    logic        rd_nwr = 1'b1;
    logic        sel0_n = 1'b1;
    logic        sel1_n = 1'b1;
    logic        sel2 = 1'b0;
    logic [7:0]  addr = '0;
    logic [3:0]  lane_we_n = 4'hF;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    zbt_sram dut (
        .clk(clk), .rst_n(rst_n), .snooze(snooze), .clk_en_n(clk_en_n),
        .load_n(load_n), .rd_nwr(rd_nwr), .sel0_n(sel0_n), .sel1_n(sel1_n),
        .sel2(sel2), .addr(addr), .lane_we_n(lane_we_n), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid)
    );

    // ds: 0 selected, 1 sel0_n high, 2 sel1_n high, 3 sel2 low
    typedef struct packed {
        logic        ld_n;
        logic        rnw;
        logic [1:0]  ds;
        logic [7:0]  a;
        logic [3:0]  be_n;
        logic [31:0] wd;
        logic        exp_v;
        logic [31:0] exp_d;
    } vec_t;

    localparam vec_t VEC [0:16] = '{
        '{1'b0, 1'b0, 2'd0, 8'h10, 4'hF, 32'h0,        1'b0, 32'h0},        // write 10
        '{1'b0, 1'b0, 2'd0, 8'h11, 4'hF, 32'h0,        1'b0, 32'h0},        // write 11
        '{1'b0, 1'b1, 2'd0, 8'h10, 4'h0, 32'hA0A0A0A0, 1'b0, 32'h0},        // read 10, data for v0
        '{1'b0, 1'b1, 2'd0, 8'h11, 4'h0, 32'hB1B1B1B1, 1'b0, 32'h0},        // read 11, data for v1
        '{1'b0, 1'b0, 2'd0, 8'h10, 4'hF, 32'h0,        1'b1, 32'hA0A0A0A0}, // partial write 10
        '{1'b0, 1'b1, 2'd0, 8'h10, 4'hF, 32'h0,        1'b1, 32'hB1B1B1B1}, // read 10
        '{1'b0, 1'b0, 2'd3, 8'h11, 4'b1010, 32'h11223344, 1'b0, 32'h0},     // deselected load
        '{1'b1, 1'b1, 2'd0, 8'h00, 4'h0, 32'hFFFFFFFF, 1'b1, 32'hA022A044}, // advance after desel
        '{1'b0, 1'b1, 2'd0, 8'h11, 4'h0, 32'hFFFFFFFF, 1'b0, 32'h0},        // read 11
        '{1'b0, 1'b0, 2'd0, 8'h1E, 4'hF, 32'h0,        1'b0, 32'h0},        // burst write 1E
        '{1'b1, 1'b1, 2'd3, 8'h00, 4'hF, 32'h0,        1'b1, 32'hB1B1B1B1}, // advance 1F
        '{1'b1, 1'b1, 2'd3, 8'h00, 4'h0, 32'h0000001E, 1'b0, 32'h0},        // advance 1C
        '{1'b0, 1'b1, 2'd0, 8'h1E, 4'h0, 32'h0000001F, 1'b0, 32'h0},        // burst read 1E
        '{1'b1, 1'b0, 2'd1, 8'h00, 4'h0, 32'h0000001C, 1'b0, 32'h0},        // advance 1F
        '{1'b1, 1'b0, 2'd2, 8'h00, 4'hF, 32'h0,        1'b1, 32'h0000001E}, // advance 1C
        '{1'b0, 1'b1, 2'd1, 8'h00, 4'hF, 32'h0,        1'b1, 32'h0000001F}, // deselected
        '{1'b0, 1'b1, 2'd2, 8'h00, 4'hF, 32'h0,        1'b1, 32'h0000001C}  // deselected
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic ld, input logic rnw, input logic [1:0] ds,
                         input logic [7:0] a, input logic [3:0] be, input logic [31:0] wd);
        load_n    = ld;
        rd_nwr    = rnw;
        sel0_n    = (ds == 2'd1);
        sel1_n    = (ds == 2'd2);
        sel2      = (ds != 2'd3);
        addr      = a;
        lane_we_n = be;
        wdata     = wd;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 5000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 rvalid", {31'b0, rvalid}, 32'h0);
        chk("R9 rdata", rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector walk: R1 R2 R3 R5 R6 R7 R10
        for (int i = 0; i < 17; i++) begin
            drive(VEC[i].ld_n, VEC[i].rnw, VEC[i].ds, VEC[i].a, VEC[i].be_n, VEC[i].wd);
            tick();
            chk($sformatf("R1/R10 rvalid vec%0d", i), {31'b0, rvalid}, {31'b0, VEC[i].exp_v});
            if (VEC[i].exp_v)
                chk($sformatf("R2/R3/R6 rdata vec%0d", i), rdata, VEC[i].exp_d);
        end

        // R4 stall: read 1E issued, then stalled with a conflicting write presented
        drive(1'b0, 1'b1, 2'd0, 8'h1E, 4'hF, 32'h0);
        tick();
        clk_en_n = 1'b1;
        drive(1'b0, 1'b0, 2'd0, 8'h1F, 4'h0, 32'hDEADBEEF);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R4 no result during stall", {31'b0, rvalid}, 32'h0);
        end
        clk_en_n = 1'b0;
        drive(1'b0, 1'b1, 2'd3, 8'h00, 4'hF, 32'h0);
        tick();
        chk("R4 one edge after stall", {31'b0, rvalid}, 32'h0);
        tick();
        chk("R4 delayed result valid", {31'b0, rvalid}, 32'h1);
        chk("R4 delayed result data", rdata, 32'h0000001E);
        clk_en_n = 1'b1;
        drive(1'b0, 1'b0, 2'd0, 8'h1F, 4'h0, 32'hDEADBEEF);
        tick();
        tick();
        chk("R4 held valid", {31'b0, rvalid}, 32'h1);
        chk("R4 held data", rdata, 32'h0000001E);
        clk_en_n = 1'b0;
        drive(1'b0, 1'b1, 2'd3, 8'h00, 4'hF, 32'h0);
        tick();
        chk("R4 result retired", {31'b0, rvalid}, 32'h0);
        drive(1'b0, 1'b1, 2'd0, 8'h1F, 4'hF, 32'h0);
        tick();
        drive(1'b0, 1'b1, 2'd3, 8'h00, 4'hF, 32'h0);
        tick();
        tick();
        chk("R4 stalled write ignored", rdata, 32'h0000001F);

        // R8 snooze
        drive(1'b0, 1'b1, 2'd0, 8'h1C, 4'hF, 32'h0);
        tick();
        drive(1'b0, 1'b1, 2'd3, 8'h00, 4'hF, 32'h0);
        tick();
        tick();
        chk("R8 pre-snooze valid", {31'b0, rvalid}, 32'h1);
        snooze = 1'b1;
        #1;
        chk("R8 async drop of rvalid", {31'b0, rvalid}, 32'h0);
        drive(1'b0, 1'b0, 2'd0, 8'h1C, 4'h0, 32'hFFFFFFFF);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R8 snooze quiet", {31'b0, rvalid}, 32'h0);
        end
        snooze = 1'b0;
        drive(1'b1, 1'b1, 2'd0, 8'h1C, 4'hF, 32'h0);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R8 pipeline empty after wake", {31'b0, rvalid}, 32'h0);
        end
        drive(1'b0, 1'b1, 2'd0, 8'h1C, 4'hF, 32'h0);
        tick();
        drive(1'b0, 1'b1, 2'd3, 8'h00, 4'hF, 32'h0);
        tick();
        tick();
        chk("R8 contents kept valid", {31'b0, rvalid}, 32'h1);
        chk("R8 contents kept data", rdata, 32'h0000001C);

        summary();
    end

endmodule